// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sits between a processor core and an off-chip memory bus. It runs one access at a time. The core starts an access with a single-cycle request that gives the address space (program, data or I/O), the direction, the address, the write data and the number of software wait states. The block then drives the active-low space selects and strobes and the read/write line for the whole access. It stretches the access by the software wait-state count. When that count is two or more, it keeps stretching the access for as long as the external READY input is low.

A microstate-complete output stays low across the software wait window. When that output is wired back to READY, it adds exactly one external wait state. A bus hold request is granted only between accesses, and while it is granted the bus drivers are disabled. A global output-off input disables every output driver. The pads themselves are outside this block, so each group of drivers is controlled by an output-enable port.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the space selects, both strobes, rw_o, msc_no and holda_no are high, done_o is low, and bus_oe_o and aux_oe_o follow off_ni.
- R2: During every cycle of an access exactly one space select is low, and the space code picks it: 2'b00 gives ps_no, 2'b01 gives ds_no, and any code with bit 1 set gives is_no. bus_addr_o carries the request address for the whole access.
- R3: mstrb_no is low in every access cycle of a program or data access. iostrb_no is low in every access cycle of an I/O access. The two strobes are never low together, and outside an access both are high.
- R4: rw_o is low only during the cycles of a write access. bus_wdata_o carries the write data during those cycles.
- R5: With a wait count N of 0 or 1, an access lasts N+1 cycles whatever the level of ready_i.
- R6: With N of 2 or more, ready_i is sampled first at the end of the last software wait cycle, not earlier. Each low sample adds one cycle and ready_i is sampled again, so the access lasts N+1+L cycles for L low samples.
- R7: With N of 2 or more, msc_no is low in software wait cycles 1 through N of the access and high in every other cycle. With N below 2 it stays high.
- R8: When ready_i is driven from msc_no and N is 2 or more, the access lasts exactly N+2 cycles.
- R9: done_o is high for exactly one cycle, the cycle after the last access cycle. For a read, rdata_o then holds the bus_rdata_i value from that last access cycle.
- R10: hold_ni low is granted only between accesses. An access in progress completes first. While the hold is granted, holda_no and bus_oe_o are low, no strobe is driven and requests are ignored.
- R11: One cycle after hold_ni is sampled high, holda_no returns high and bus_oe_o is reasserted.
- R12: While off_ni is low, bus_oe_o and aux_oe_o are low. Access sequencing carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle access request, taken when idle and not held |
| req_space_i | input | 2 | Space code: 00 program, 01 data, 1x I/O |
| req_we_i | input | 1 | 1 for a write access |
| req_ws_i | input | WS_W | Software wait-state count |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | External address |
| bus_wdata_o | output | DW | External write data |
| bus_rdata_i | input | DW | External read data |
| ps_no | output | 1 | Program space select, active low |
| ds_no | output | 1 | Data space select, active low |
| is_no | output | 1 | I/O space select, active low |
| mstrb_no | output | 1 | Memory strobe, active low |
| iostrb_no | output | 1 | I/O strobe, active low |
| rw_o | output | 1 | High for a read, low for a write |
| ready_i | input | 1 | External ready |
| msc_no | output | 1 | Software wait window marker, active low |
| hold_ni | input | 1 | Bus hold request, active low |
| holda_no | output | 1 | Hold grant, active low |
| off_ni | input | 1 | Global output-off control, active low |
| bus_oe_o | output | 1 | Enable for address, data, selects, strobes and rw |
| aux_oe_o | output | 1 | Enable for holda_no and msc_no |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. At most one select is low at a time. The strobes never overlap, and each strobe matches its select. A write level or an MSC low never appears outside an access. The done pulse lasts one cycle and always follows an access cycle. Nothing is driven during a hold, the hold grant drops one cycle after the request is removed, and output-off wins over every enable.

Other behaviour depends on counting cycles against the request, and only the bench scenarios can show it. These cases are:
- the access length for each wait count and READY pattern;
- that READY is ignored below two wait states and is not looked at before the last wait cycle;
- the single extra cycle under MSC loopback;
- the captured read data;
- that an access already running finishes before the hold is granted.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SWAIT,
    ST_XWAIT,
    ST_HOLD
  } ebus_st_e;

  localparam int unsigned N_SPACE = 3;
  localparam int unsigned SP_PROG = 0;
  localparam int unsigned SP_DATA = 1;
  localparam int unsigned SP_IO   = 2;

  typedef struct packed {
    logic [N_SPACE-1:0] sel_n;   // {io, data, prog}
    logic               mstrb_n;
    logic               iostrb_n;
    logic               rw;
  } ebus_ctl_t;
endpackage

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int unsigned WS_W = 3,
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      req_space_i,
  input  logic            req_we_i,
  input  logic [WS_W-1:0] req_ws_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic            ready_i,
  input  logic            hold_ni,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic            active_o,
  output logic            in_hold_o,
  output logic            msc_win_o,
  output logic [1:0]      space_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o
);
  localparam logic [WS_W-1:0] WS_ONE  = WS_W'(1);
  localparam logic [WS_W-1:0] WS_LONG = WS_W'(2);

  ebus_st_e        st_q, st_d;
  logic [WS_W-1:0] cnt_q, cnt_d, ws_q;
  logic [1:0]      sp_q;
  logic            we_q, done_q, fin, accept, long_w;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  // ready only matters for long software waits
  assign long_w = (ws_q >= WS_LONG);
  assign accept = (st_q == ST_IDLE) && hold_ni && req_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (!hold_ni) st_d = ST_HOLD;
                else if (req_i) st_d = ST_ADDR;
      ST_ADDR:  if (ws_q == '0) fin = 1'b1;
                else begin
                  st_d  = ST_SWAIT;
                  cnt_d = WS_ONE;
                end
      ST_SWAIT: if (cnt_q != ws_q) cnt_d = cnt_q + WS_ONE;
                else if (long_w && !ready_i) st_d = ST_XWAIT;
                else fin = 1'b1;
      ST_XWAIT: if (ready_i) fin = 1'b1;
      ST_HOLD:  if (hold_ni) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ws_q    <= '0;
      sp_q    <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= fin;
      if (fin && !we_q) rdata_q <= bus_rdata_i;
      if (accept) begin
        ws_q    <= req_ws_i;
        sp_q    <= req_space_i;
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign active_o  = (st_q == ST_ADDR) || (st_q == ST_SWAIT) || (st_q == ST_XWAIT);
  assign in_hold_o = (st_q == ST_HOLD);
  assign msc_win_o = (st_q == ST_SWAIT) && long_w;
  assign space_o   = sp_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/ebus_decode.sv
module ebus_decode
  import ebus_pkg::*;
(
  input  logic      active_i,
  input  logic [1:0] space_i,
  input  logic      we_i,
  output ebus_ctl_t ctl_o
);
  logic [N_SPACE-1:0] hit;

  always_comb begin
    hit         = '0;
    hit[SP_IO]   = space_i[1];
    hit[SP_DATA] = !space_i[1] && space_i[0];
    hit[SP_PROG] = !space_i[1] && !space_i[0];
  end

  for (genvar i = 0; i < N_SPACE; i++) begin : g_sel
    assign ctl_o.sel_n[i] = !(active_i && hit[i]);
  end

  assign ctl_o.mstrb_n  = !(active_i && (hit[SP_PROG] || hit[SP_DATA]));
  assign ctl_o.iostrb_n = !(active_i && hit[SP_IO]);
  assign ctl_o.rw       = !(active_i && we_i);
endmodule

// File: rtl/ebus_oe.sv
module ebus_oe (
  input  logic off_ni,
  input  logic in_hold_i,
  input  logic msc_win_i,
  output logic bus_oe_o,
  output logic aux_oe_o,
  output logic holda_no,
  output logic msc_no
);
  assign bus_oe_o = off_ni && !in_hold_i;
  assign aux_oe_o = off_ni;
  assign holda_no = !in_hold_i;
  assign msc_no   = !msc_win_i;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebus_pkg::*;
#(
  parameter int unsigned WS_W = 3,
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      req_space_i,
  input  logic            req_we_i,
  input  logic [WS_W-1:0] req_ws_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic            ps_no,
  output logic            ds_no,
  output logic            is_no,
  output logic            mstrb_no,
  output logic            iostrb_no,
  output logic            rw_o,
  input  logic            ready_i,
  output logic            msc_no,
  input  logic            hold_ni,
  output logic            holda_no,
  input  logic            off_ni,
  output logic            bus_oe_o,
  output logic            aux_oe_o
);
  logic       active, in_hold, msc_win, we;
  logic [1:0] space;
  ebus_ctl_t  ctl;

  ebus_seq #(.WS_W(WS_W), .AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_space_i (req_space_i),
    .req_we_i    (req_we_i),
    .req_ws_i    (req_ws_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ready_i     (ready_i),
    .hold_ni     (hold_ni),
    .bus_rdata_i (bus_rdata_i),
    .active_o    (active),
    .in_hold_o   (in_hold),
    .msc_win_o   (msc_win),
    .space_o     (space),
    .we_o        (we),
    .addr_o      (bus_addr_o),
    .wdata_o     (bus_wdata_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o)
  );

  ebus_decode u_dec (
    .active_i (active),
    .space_i  (space),
    .we_i     (we),
    .ctl_o    (ctl)
  );

  ebus_oe u_oe (
    .off_ni    (off_ni),
    .in_hold_i (in_hold),
    .msc_win_i (msc_win),
    .bus_oe_o  (bus_oe_o),
    .aux_oe_o  (aux_oe_o),
    .holda_no  (holda_no),
    .msc_no    (msc_no)
  );

  assign ps_no     = ctl.sel_n[SP_PROG];
  assign ds_no     = ctl.sel_n[SP_DATA];
  assign is_no     = ctl.sel_n[SP_IO];
  assign mstrb_no  = ctl.mstrb_n;
  assign iostrb_no = ctl.iostrb_n;
  assign rw_o      = ctl.rw;
endmodule

// File: rtl/ebus_chk.sv
module ebus_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ps_no,
  input logic ds_no,
  input logic is_no,
  input logic mstrb_no,
  input logic iostrb_no,
  input logic rw_o,
  input logic msc_no,
  input logic holda_no,
  input logic hold_ni,
  input logic off_ni,
  input logic bus_oe_o,
  input logic aux_oe_o,
  input logic done_o
);
  logic acc;
  assign acc = !mstrb_no || !iostrb_no;

  assert_one_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!ps_no, !ds_no, !is_no}) <= 1);
  assert_strb_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mstrb_no && !iostrb_no));
  assert_mstrb_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mstrb_no |-> (!ps_no || !ds_no));
  assert_iostrb_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iostrb_no |-> !is_no);
  assert_rw_in_acc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_o |-> acc);
  assert_msc_in_acc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msc_no |-> acc);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(acc));
  assert_hold_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !holda_no |-> (!acc && !bus_oe_o));
  assert_hold_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!holda_no && hold_ni) |=> (holda_no && (bus_oe_o == off_ni)));
  assert_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_ni |-> (!bus_oe_o && !aux_oe_o));
endmodule

bind ext_bus_seq ebus_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ps_no     (ps_no),
  .ds_no     (ds_no),
  .is_no     (is_no),
  .mstrb_no  (mstrb_no),
  .iostrb_no (iostrb_no),
  .rw_o      (rw_o),
  .msc_no    (msc_no),
  .holda_no  (holda_no),
  .hold_ni   (hold_ni),
  .off_ni    (off_ni),
  .bus_oe_o  (bus_oe_o),
  .aux_oe_o  (aux_oe_o),
  .done_o    (done_o)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WS_W = 3;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] RD_KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            req_i = 1'b0, req_we_i = 1'b0;
  logic [1:0]      req_space_i = '0;
  logic [WS_W-1:0] req_ws_i = '0;
  logic [AW-1:0]   req_addr_i = '0;
  logic [DW-1:0]   req_wdata_i = '0;
  logic            hold_ni = 1'b1, off_ni = 1'b1;
  logic            ready_drv = 1'b0, loop_en = 1'b0;
  logic            done_o, rw_o, msc_no, holda_no, bus_oe_o, aux_oe_o;
  logic            ps_no, ds_no, is_no, mstrb_no, iostrb_no, ready_i;
  logic [DW-1:0]   rdata_o, bus_wdata_o, bus_rdata_i;
  logic [AW-1:0]   bus_addr_o;

  assign ready_i     = loop_en ? msc_no : ready_drv;
  assign bus_rdata_i = bus_addr_o ^ RD_KEY;

  ext_bus_seq #(.WS_W(WS_W), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_space_i(req_space_i),
    .req_we_i(req_we_i), .req_ws_i(req_ws_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .done_o(done_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .ps_no(ps_no), .ds_no(ds_no), .is_no(is_no), .mstrb_no(mstrb_no),
    .iostrb_no(iostrb_no), .rw_o(rw_o), .ready_i(ready_i), .msc_no(msc_no),
    .hold_ni(hold_ni), .holda_no(holda_no), .off_ni(off_ni),
    .bus_oe_o(bus_oe_o), .aux_oe_o(aux_oe_o)
  );

  typedef struct {
    logic [1:0] sp;
    logic       we;
    int         ws;
    int         lows;
    logic       loop;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } item_t;

  item_t q[$];
  item_t cur;
  int checks = 0, errors = 0, done_cnt = 0, k = 0, exp_len = 0;
  bit finished = 1'b0;
  logic [2:0] exp_sel;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every access cycle and every completion to the queue head
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (!mstrb_no || !iostrb_no) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected access", 32'd1, 32'd0);
        end else begin
          cur = q[0];
          exp_sel = cur.sp[1] ? 3'b110 : (cur.sp[0] ? 3'b101 : 3'b011);
          chk({ps_no, ds_no, is_no} == exp_sel, "R2", "selects", {29'd0, ps_no, ds_no, is_no}, {29'd0, exp_sel});
          chk(bus_addr_o == cur.addr, "R2", "address", 32'(bus_addr_o), 32'(cur.addr));
          chk({mstrb_no, iostrb_no} == (cur.sp[1] ? 2'b10 : 2'b01), "R3", "strobes",
              {30'd0, mstrb_no, iostrb_no}, cur.sp[1] ? 32'd2 : 32'd1);
          chk(rw_o == !cur.we, "R4", "rw", 32'(rw_o), 32'(!cur.we));
          if (cur.we) chk(bus_wdata_o == cur.wdata, "R4", "wdata", 32'(bus_wdata_o), 32'(cur.wdata));
          chk(msc_no == !(cur.ws >= 2 && k >= 1 && k <= cur.ws), "R7", "msc",
              32'(msc_no), 32'(!(cur.ws >= 2 && k >= 1 && k <= cur.ws)));
          // ready for the coming edge: low early and through the wanted low samples
          ready_drv = (cur.ws < 2) ? 1'b0 : ((k < cur.ws + cur.lows) ? 1'b0 : 1'b1);
        end
        k++;
      end else begin
        chk(msc_no == 1'b1, "R7", "msc idle", 32'(msc_no), 32'd1);
        chk({rw_o, mstrb_no, iostrb_no} == 3'b111, "R3", "idle strobes",
            {29'd0, rw_o, mstrb_no, iostrb_no}, 32'd7);
      end
      if (done_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "done without access", 32'd1, 32'd0);
        end else begin
          cur = q.pop_front();
          exp_len = (cur.ws < 2) ? cur.ws + 1 : (cur.loop ? cur.ws + 2 : cur.ws + 1 + cur.lows);
          chk(k == exp_len, (cur.ws < 2) ? "R5" : (cur.loop ? "R8" : "R6"), "length",
              32'(k), 32'(exp_len));
          if (!cur.we) chk(rdata_o == (cur.addr ^ RD_KEY), "R9", "rdata",
                           32'(rdata_o), 32'(cur.addr ^ RD_KEY));
        end
        k = 0;
        done_cnt++;
      end
    end
  end

  // driver: queue the expectation, pulse the request, return on the done cycle
  task automatic access(input logic [1:0] sp, input logic we, input int ws,
                        input int lows, input logic loop,
                        input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    item_t it;
    it.sp = sp; it.we = we; it.ws = ws; it.lows = lows; it.loop = loop;
    it.addr = addr; it.wdata = wd;
    q.push_back(it);
    loop_en     = loop;
    req_space_i = sp;
    req_we_i    = we;
    req_ws_i    = WS_W'(ws);
    req_addr_i  = addr;
    req_wdata_i = wd;
    req_i       = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    @(posedge done_o);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ps_no, ds_no, is_no, mstrb_no, iostrb_no, rw_o, msc_no, holda_no} == 8'hFF,
        "R1", "idle levels", {24'd0, ps_no, ds_no, is_no, mstrb_no, iostrb_no, rw_o, msc_no, holda_no}, 32'hFF);
    chk({done_o, bus_oe_o, aux_oe_o} == 3'b011, "R1", "done/oe", {29'd0, done_o, bus_oe_o, aux_oe_o}, 32'd3);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 short waits, ready held low and ignored
    access(2'b00, 1'b0, 0, 0, 1'b0, 16'h0100, 16'h0);
    access(2'b01, 1'b1, 1, 0, 1'b0, 16'h0201, 16'h1234);
    access(2'b10, 1'b0, 0, 0, 1'b0, 16'h0302, 16'h0);
    access(2'b11, 1'b1, 1, 0, 1'b0, 16'h0403, 16'hBEEF);
    access(2'b01, 1'b0, 1, 0, 1'b0, 16'h0504, 16'h0);
    // R6 long waits with various ready patterns
    access(2'b00, 1'b0, 2, 0, 1'b0, 16'h1000, 16'h0);
    access(2'b01, 1'b0, 3, 2, 1'b0, 16'h1101, 16'h0);
    access(2'b01, 1'b1, 5, 1, 1'b0, 16'h1202, 16'hCAFE);
    access(2'b10, 1'b0, 7, 0, 1'b0, 16'h1303, 16'h0);
    access(2'b10, 1'b1, 4, 3, 1'b0, 16'h1404, 16'h5555);
    // R8 msc looped back to ready
    access(2'b00, 1'b0, 2, 0, 1'b1, 16'h2000, 16'h0);
    access(2'b10, 1'b0, 4, 0, 1'b1, 16'h2101, 16'h0);
    loop_en = 1'b0;

    // R10 hold raised mid-access: access completes first
    q.push_back('{sp:2'b01, we:1'b0, ws:3, lows:0, loop:1'b0, addr:16'h3000, wdata:16'h0});
    req_space_i = 2'b01; req_we_i = 1'b0; req_ws_i = 3'd3; req_addr_i = 16'h3000;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    hold_ni = 1'b0;
    @(posedge done_o);
    @(negedge clk);
    @(negedge clk);
    chk(holda_no == 1'b0, "R10", "holda granted", 32'(holda_no), 32'd0);
    chk(bus_oe_o == 1'b0, "R10", "bus floated", 32'(bus_oe_o), 32'd0);
    base = done_cnt;
    req_space_i = 2'b00; req_i = 1'b1;
    repeat (3) @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    chk(done_cnt == base, "R10", "request ignored in hold", 32'(done_cnt), 32'(base));
    chk(holda_no == 1'b0, "R11", "holda kept while requested", 32'(holda_no), 32'd0);
    hold_ni = 1'b1;
    @(negedge clk);
    chk({holda_no, bus_oe_o} == 2'b11, "R11", "release", {30'd0, holda_no, bus_oe_o}, 32'd3);

    // R12 output off during an access
    off_ni = 1'b0;
    @(negedge clk);
    chk({bus_oe_o, aux_oe_o} == 2'b00, "R12", "outputs off", {30'd0, bus_oe_o, aux_oe_o}, 32'd0);
    access(2'b10, 1'b0, 3, 1, 1'b0, 16'h4000, 16'h0);
    chk({bus_oe_o, aux_oe_o} == 2'b00, "R12", "off after access", {30'd0, bus_oe_o, aux_oe_o}, 32'd0);
    off_ni = 1'b1;
    @(negedge clk);
    chk({bus_oe_o, aux_oe_o} == 2'b11, "R12", "outputs on", {30'd0, bus_oe_o, aux_oe_o}, 32'd3);
    chk(q.size() == 0, "R9", "all accesses completed", 32'(q.size()), 32'd0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule